// File: doc/BRIEF.md
# Asynchronous Bus Slave Register Port

This block is the slave side of a simple I/O controller on an asynchronous, fully interlocked bus. The bus has an 18-bit byte address and a 16-bit data path. The block holds a small file of 16-bit registers and responds only to addresses in its window. That window is a parameterised offset inside the 8 kB device page at the top of the address space.

A master places address, cycle code and write data on the bus and then raises master sync. Master sync is resynchronised into the block clock. The block decodes the cycle, carries out the access and raises slave sync. It holds slave sync until master sync falls, and then releases it. Four cycle types are handled:

- word read
- read with pause, which opens a read-modify-write
- word write
- byte write

A read with pause locks the slave onto the register it just read. Only a write to that register, which completes the read-modify-write, is answered after it.

The synchronous initialise input clears all registers and any open read-modify-write.

Top module: `ubs_slave`

## Requirements
- R1: After reset, slave sync is low, read data is zero and every register reads back 0x0000.
- R2: A cycle is answered only when address bits 17..13 are all ones and the offset in bits 12..0 lies in [BASE_OFF, BASE_OFF + 2*NUM_REGS). Any other address never raises slave sync. Register index is (offset - BASE_OFF) >> 1.
- R3: Slave sync rises only while master sync is high, stays high for as long as master sync is high, and falls within a bounded number of clocks after master sync falls.
- R4: A word read (control code 00) returns the addressed register on the data output. The data output is zero whenever slave sync is low.
- R5: A word write (control code 10) replaces all 16 bits of the addressed register.
- R6: A byte write (control code 11) changes only one byte. Address bit 0 = 0 selects bits 7..0 and address bit 0 = 1 selects bits 15..8. The other byte is left unchanged.
- R7: A read with pause (control code 01) returns the register like a word read and opens a pending read-modify-write. A later word or byte write to the same register is answered and closes it.
- R8: While a read-modify-write is pending, every cycle other than a write to the paused register gets no slave sync and changes no register.
- R9: Asserting the initialise input clears every register to 0x0000 and cancels a pending read-modify-write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| init_i | input | 1 | Synchronous bus initialise |
| addr_i | input | 18 | Bus byte address |
| ctrl_i | input | 2 | Cycle control code |
| data_i | input | 16 | Write data from master |
| msync_i | input | 1 | Master sync strobe (asynchronous) |
| ssync_o | output | 1 | Slave sync response |
| data_o | output | 16 | Read data, zero when not driven |
| data_oe_o | output | 1 | Read data valid/drive enable |

## Verification
The assertions assume the master follows the interlock. Address, control code and write data are stable from before master sync rises until slave sync falls. Master sync is not raised again until slave sync has dropped. Every bench cycle sets up the bus one clock before raising master sync, waits for slave sync or a timeout, and waits for slave sync to be released before the next cycle. Initialise is pulsed only between cycles. Random addresses are aimed mostly at and around the register window, so that both hits and misses occur.

// File: rtl/ubs_pkg.sv
package ubs_pkg;
  typedef enum logic [1:0] {
    CYC_RD    = 2'b00,
    CYC_RDP   = 2'b01,
    CYC_WR    = 2'b10,
    CYC_WRB   = 2'b11
  } cyc_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ACK  = 2'd1,
    ST_NACK = 2'd2
  } st_e;
endpackage

// File: rtl/ubs_sync.sv
module ubs_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sr_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sr_q <= '0;
        else         sr_q <= d_i;
    end else begin : g_many
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sr_q <= '0;
        else         sr_q <= {sr_q[STAGES-2:0], d_i};
    end
  endgenerate

  assign q_o = sr_q[STAGES-1];
endmodule

// File: rtl/ubs_decode.sv
module ubs_decode #(
  parameter int ADDR_W   = 18,
  parameter int PAGE_W   = 13,
  parameter int BASE_OFF = 13'h1F00,
  parameter int NUM_REGS = 8,
  localparam int IDX_W   = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic              hit_o,
  output logic [IDX_W-1:0]  idx_o
);
  localparam int TOP_W   = ADDR_W - PAGE_W;
  localparam int WIN_END = BASE_OFF + 2 * NUM_REGS;

  logic [PAGE_W-1:0] off;
  logic [PAGE_W-1:0] rel;
  logic              in_page;

  assign off     = addr_i[PAGE_W-1:0];
  assign in_page = &addr_i[ADDR_W-1:PAGE_W];
  assign rel     = off - PAGE_W'(BASE_OFF);
  assign hit_o   = in_page && (int'(off) >= BASE_OFF) && (int'(off) < WIN_END);
  assign idx_o   = rel[IDX_W:1];

  initial begin
    assert (TOP_W > 0 && WIN_END <= (1 << PAGE_W))
      else $error("register window does not fit device page");
  end
endmodule

// File: rtl/ubs_regfile.sv
module ubs_regfile #(
  parameter int NUM_REGS = 8,
  parameter int DATA_W   = 16,
  localparam int IDX_W   = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1,
  localparam int NB      = DATA_W / 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              we_i,
  input  logic [NB-1:0]     be_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] regs_q [NUM_REGS];

  for (genvar r = 0; r < NUM_REGS; r++) begin : g_reg
    for (genvar b = 0; b < NB; b++) begin : g_byte
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni)
          regs_q[r][8*b +: 8] <= '0;
        else if (clr_i)
          regs_q[r][8*b +: 8] <= '0;
        else if (we_i && be_i[b] && idx_i == IDX_W'(r))
          regs_q[r][8*b +: 8] <= wdata_i[8*b +: 8];
    end
  end

  assign rdata_o = regs_q[idx_i];

  // R6: low-lane byte write leaves the high byte alone
  a_r6_high_kept: assert property (@(posedge clk_i) disable iff (!rst_ni || clr_i)
    (we_i && be_i == 2'b01) |=> (regs_q[$past(idx_i)][15:8] == $past(regs_q[idx_i][15:8])));
  a_r6_low_kept: assert property (@(posedge clk_i) disable iff (!rst_ni || clr_i)
    (we_i && be_i == 2'b10) |=> (regs_q[$past(idx_i)][7:0] == $past(regs_q[idx_i][7:0])));
  // R9: clear empties the file
  a_r9_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (regs_q[0] == '0));
endmodule

// File: rtl/ubs_slave.sv
module ubs_slave
  import ubs_pkg::*;
#(
  parameter int ADDR_W      = 18,
  parameter int DATA_W      = 16,
  parameter int PAGE_W      = 13,
  parameter int BASE_OFF    = 13'h1F00,
  parameter int NUM_REGS    = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              init_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [1:0]        ctrl_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              msync_i,
  output logic              ssync_o,
  output logic [DATA_W-1:0] data_o,
  output logic              data_oe_o
);
  localparam int IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;
  localparam int NB    = DATA_W / 8;

  st_e               st_q;
  logic              msync_s;
  logic              hit;
  logic [IDX_W-1:0]  idx;
  logic              pend_q;
  logic [IDX_W-1:0]  pend_idx_q;
  logic              ssync_q;
  logic              oe_q;
  logic [DATA_W-1:0] rd_q;
  logic [DATA_W-1:0] rf_rdata;
  logic              is_wr;
  logic              allow;
  logic              start;
  logic              we;
  logic [NB-1:0]     be;
  cyc_e              cyc;

  ubs_sync #(.STAGES(SYNC_STAGES)) u_msync (
    .clk_i (clk_i), .rst_ni(rst_ni), .d_i(msync_i), .q_o(msync_s)
  );

  ubs_decode #(
    .ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .BASE_OFF(BASE_OFF), .NUM_REGS(NUM_REGS)
  ) u_dec (
    .addr_i(addr_i), .hit_o(hit), .idx_o(idx)
  );

  assign cyc   = cyc_e'(ctrl_i);
  assign is_wr = (cyc == CYC_WR) || (cyc == CYC_WRB);
  // open read-modify-write admits only its completing write
  assign allow = hit && (!pend_q || (is_wr && idx == pend_idx_q));
  assign start = (st_q == ST_IDLE) && msync_s && !init_i;
  assign we    = start && allow && is_wr;

  always_comb begin
    be = '1;
    if (cyc == CYC_WRB) begin
      be = '0;
      be[addr_i[0]] = 1'b1;
    end
  end

  logic [DATA_W-1:0] wdata;
  assign wdata = (cyc == CYC_WRB) ? {NB{data_i[7:0]}} & {NB{8'hFF}} : data_i;

  ubs_regfile #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W)) u_rf (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (init_i),
    .we_i   (we),
    .be_i   (be),
    .idx_i  (idx),
    .wdata_i(wdata),
    .rdata_o(rf_rdata)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q       <= ST_IDLE;
      ssync_q    <= 1'b0;
      oe_q       <= 1'b0;
      rd_q       <= '0;
      pend_q     <= 1'b0;
      pend_idx_q <= '0;
    end else if (init_i) begin
      st_q    <= ST_IDLE;
      ssync_q <= 1'b0;
      oe_q    <= 1'b0;
      rd_q    <= '0;
      pend_q  <= 1'b0;
    end else begin
      unique case (st_q)
        ST_IDLE: if (msync_s) begin
          if (allow) begin
            st_q    <= ST_ACK;
            ssync_q <= 1'b1;
            oe_q    <= !is_wr;
            rd_q    <= is_wr ? '0 : rf_rdata;
            if (cyc == CYC_RDP) begin
              pend_q     <= 1'b1;
              pend_idx_q <= idx;
            end else if (is_wr) begin
              pend_q <= 1'b0;
            end
          end else begin
            st_q <= ST_NACK;
          end
        end
        ST_ACK: if (!msync_s) begin
          st_q    <= ST_IDLE;
          ssync_q <= 1'b0;
          oe_q    <= 1'b0;
          rd_q    <= '0;
        end
        ST_NACK: if (!msync_s) st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign ssync_o   = ssync_q;
  assign data_oe_o = oe_q;
  assign data_o    = rd_q;

  // R3: response only follows a synchronised strobe
  a_r3_rise_on_msync: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ssync_q) |-> msync_s);
  // R3: response held while strobe stays high
  a_r3_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ssync_q && msync_s && !init_i) |=> ssync_q);
  // R2: rejected cycle never answers
  a_r2_miss_silent: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_NACK) |-> !ssync_q);
  // R4: read data stable through the response window
  a_r4_data_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ssync_q && $past(ssync_q) && !$past(init_i)) |-> $stable(data_o));
  // R4: no data driven without a response
  a_r4_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ssync_q |-> (data_o == '0 && !data_oe_o));
  // R8: while paused, only a write is answered
  a_r8_pause_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(ssync_q) && $past(pend_q)) |-> !oe_q);
endmodule

// File: tb/ubs_slave_tb.sv
module ubs_slave_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NREG       = 8;
  localparam logic [17:0] BASE = 18'h3FF00;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        init_i = 1'b0;
  logic [17:0] addr_i = '0;
  logic [1:0]  ctrl_i = '0;
  logic [15:0] data_i = '0;
  logic        msync_i = 1'b0;
  logic        ssync_o;
  logic [15:0] data_o;
  logic        data_oe_o;

  int checks = 0;
  int errors = 0;
  logic [15:0] model [NREG];
  logic        pend = 1'b0;
  int          pidx = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ubs_slave u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .init_i(init_i), .addr_i(addr_i),
    .ctrl_i(ctrl_i), .data_i(data_i), .msync_i(msync_i),
    .ssync_o(ssync_o), .data_o(data_o), .data_oe_o(data_oe_o)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic bit in_win(logic [17:0] a);
    return a >= BASE && a < BASE + 18'(2*NREG);
  endfunction

  function automatic int idx_of(logic [17:0] a);
    return int'((a - BASE) >> 1);
  endfunction

  function automatic bit exp_ack(logic [17:0] a, logic [1:0] c);
    if (!in_win(a)) return 1'b0;
    if (!pend) return 1'b1;
    return c[1] && idx_of(a) == pidx;
  endfunction

  task automatic bus(input logic [17:0] a, input logic [1:0] c, input logic [15:0] d,
                     input string req);
    bit ack = exp_ack(a, c);
    bit got = 1'b0;
    logic [15:0] rd = '0;
    int i = idx_of(a);
    @(negedge clk);
    addr_i = a; ctrl_i = c; data_i = d;
    @(negedge clk);
    msync_i = 1'b1;
    for (int k = 0; k < 12; k++) begin
      @(negedge clk);
      if (ssync_o) begin got = 1'b1; rd = data_o; break; end
    end
    check({req, " ack"}, 32'(got), 32'(ack));
    if (got) begin
      repeat (3) @(negedge clk);
      check("R3 hold", 32'(ssync_o), 32'd1);
      if (!c[1]) check({req, " rdata"}, 32'(rd), 32'(model[i]));
    end
    msync_i = 1'b0;
    repeat (6) @(negedge clk);
    check("R3 release", 32'(ssync_o), 32'd0);
    check("R4 idle data", 32'(data_o), 32'd0);
    if (ack) begin
      case (c)
        2'b01: begin pend = 1'b1; pidx = i; end
        2'b10: begin model[i] = d; pend = 1'b0; end
        2'b11: begin
          if (a[0]) model[i][15:8] = d[7:0]; else model[i][7:0] = d[7:0];
          pend = 1'b0;
        end
        default: ;
      endcase
    end
  endtask

  task automatic read_all(input string req);
    for (int r = 0; r < NREG; r++) bus(BASE + 18'(2*r), 2'b00, 16'h0, req);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    for (int r = 0; r < NREG; r++) model[r] = '0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    check("R1 ssync reset", 32'(ssync_o), 32'd0);
    check("R1 data reset", 32'(data_o), 32'd0);
    read_all("R1 regs zero");

    bus(BASE + 18'd2, 2'b10, 16'hA5C3, "R5 word write");
    bus(BASE + 18'd2, 2'b00, 16'h0, "R5 readback");
    bus(BASE + 18'd2, 2'b11, 16'h0077, "R6 byte low");
    bus(BASE + 18'd2, 2'b00, 16'h0, "R6 low readback");
    bus(BASE + 18'd3, 2'b11, 16'h0019, "R6 byte high");
    bus(BASE + 18'd2, 2'b00, 16'h0, "R6 high readback");
    bus(BASE - 18'd2, 2'b10, 16'hFFFF, "R2 below window");
    bus(BASE + 18'(2*NREG), 2'b10, 16'hFFFF, "R2 above window");
    bus(18'h1FF00, 2'b10, 16'hFFFF, "R2 outside page");
    read_all("R2 unchanged");

    bus(BASE + 18'd4, 2'b10, 16'h1234, "R7 setup");
    bus(BASE + 18'd4, 2'b01, 16'h0, "R7 read pause");
    bus(BASE + 18'd6, 2'b10, 16'hDEAD, "R8 other reg write");
    bus(BASE + 18'd4, 2'b00, 16'h0, "R8 read blocked");
    bus(BASE + 18'd4, 2'b10, 16'h5678, "R7 complete");
    read_all("R8 R7 after rmw");

    bus(BASE + 18'd8, 2'b01, 16'h0, "R9 pause before init");
    @(negedge clk); init_i = 1'b1;
    @(negedge clk); init_i = 1'b0;
    for (int r = 0; r < NREG; r++) model[r] = '0;
    pend = 1'b0;
    read_all("R9 cleared");

    for (int n = 0; n < 300; n++) begin
      logic [17:0] a;
      a = BASE - 18'd4 + 18'($urandom_range(0, 2*NREG + 7));
      if (($urandom & 15) == 0) a = 18'($urandom);
      bus(a, 2'($urandom), 16'($urandom), "R2 R4 R5 R6 R7 R8 random");
    end
    read_all("R5 R6 final");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule